// File: doc/BRIEF.md
# Single-Cycle Load-Store Processor Core

This core runs a small 32-bit load-store instruction subset and retires exactly one instruction on every rising clock edge. All state changes in an instruction land on the same edge: the program counter, the register file and the data-memory write. Each instruction word is 32 bits. The register-format layout is opcode [31:26], first source [25:21], second source [20:16], destination [15:11], shift amount [10:6] and function code [5:0]. The immediate format keeps the top three fields and puts a 16-bit immediate in [15:0].

Inside the core are the program counter, a decoder that turns the opcode and function code into a control bundle, a register file with two read ports and one write port, an immediate extender, an ALU and the next-address logic. The instruction memory and the data memory sit outside the core. Both are ideal: a read returns data in the same cycle, and a write takes effect at the clock edge while the write enable is high. Per-instruction multiplexers choose the destination index, the second ALU operand, the extension mode and the write-back source.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset sets the fetch address to 0 and clears every register, so a register read before any write returns 0.
- R2: Opcode 0x00 with function 0x21 writes rs+rt into rd. Opcode 0x00 with function 0x23 writes rs-rt into rd. Both wrap modulo 2^32.
- R3: Opcode 0x0D writes rs OR the zero-extended immediate into the register named by bits [20:16].
- R4: Opcode 0x23 loads into rt the data word at address rs plus the sign-extended immediate.
- R5: Opcode 0x2B drives the data write enable high, with address rs plus the sign-extended immediate and write data rt. It leaves the register file unchanged. The write enable is low for every other instruction and during reset.
- R6: Opcode 0x04 sets the next fetch address to PC+4+(sign-extended immediate << 2) when rs equals rt, and to PC+4 otherwise.
- R7: Every instruction other than opcode 0x04 advances the fetch address by 4. Any opcode or R-format function code not listed here only advances the fetch address.
- R8: Register 0 always reads as 0, and writes to it are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being executed (the PC) |
| imem_rdata | input | 32 | Instruction word at imem_addr, returned in the same cycle |
| dmem_addr | output | 32 | Data memory byte address (ALU result) |
| dmem_wdata | output | 32 | Store data (second source register) |
| dmem_wen | output | 1 | Data memory write enable, active for stores |
| dmem_rdata | input | 32 | Data word at dmem_addr, returned in the same cycle |

## Verification
The assertions check on every cycle that the PC clears after reset, that any instruction other than a branch steps the PC by four, that an unequal compare falls through, and that a data write happens only for the store opcode and never together with a register write. The register file's assertions check that register 0 reads as zero and that a register write lands. The cycle-by-cycle comparison against the bench's reference model is what shows the arithmetic results, the wraparound on subtraction, zero-extension versus sign-extension, a load returning the stored word, a branch taken to a computed target, and a discarded write to register 0. These become visible in the store traffic and in the final memory contents.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    localparam int XLEN      = 32;
    localparam int REG_IDX_W = 5;
    localparam int NREGS     = 1 << REG_IDX_W;
    localparam int IMM_W     = 16;

    localparam logic [5:0] OPC_REG  = 6'h00;
    localparam logic [5:0] OPC_BEQ  = 6'h04;
    localparam logic [5:0] OPC_ORI  = 6'h0D;
    localparam logic [5:0] OPC_LOAD = 6'h23;
    localparam logic [5:0] OPC_STOR = 6'h2B;

    localparam logic [5:0] FN_ADDU = 6'h21;
    localparam logic [5:0] FN_SUBU = 6'h23;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_OR  = 2'd2
    } alu_op_e;

    typedef struct packed {
        logic [5:0]           opc;
        logic [REG_IDX_W-1:0] src_a;
        logic [REG_IDX_W-1:0] src_b;
        logic [REG_IDX_W-1:0] dst;
        logic [4:0]           sh;
        logic [5:0]           fn;
    } insn_t;

    typedef struct packed {
        logic    reg_we;
        logic    dst_from_rd;
        logic    opb_imm;
        logic    ext_signed;
        logic    wb_from_mem;
        logic    mem_we;
        logic    is_branch;
        alu_op_e alu_op;
    } ctrl_t;

    function automatic logic [XLEN-1:0] extend_imm(input logic [IMM_W-1:0] imm,
                                                   input logic signed_mode);
        return {{(XLEN-IMM_W){signed_mode & imm[IMM_W-1]}}, imm};
    endfunction

endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
    import sc_core_pkg::*;
(
    input  logic [5:0] opc,
    input  logic [5:0] fn,
    output ctrl_t      ctl
);

    always_comb begin
        ctl = '{reg_we: 1'b0, dst_from_rd: 1'b0, opb_imm: 1'b0, ext_signed: 1'b0,
                wb_from_mem: 1'b0, mem_we: 1'b0, is_branch: 1'b0, alu_op: ALU_ADD};
        unique case (opc)
            OPC_REG: begin
                if (fn == FN_ADDU || fn == FN_SUBU) begin
                    ctl.reg_we      = 1'b1;
                    ctl.dst_from_rd = 1'b1;
                    ctl.alu_op      = (fn == FN_SUBU) ? ALU_SUB : ALU_ADD;
                end
            end
            OPC_ORI: begin
                ctl.reg_we  = 1'b1;
                ctl.opb_imm = 1'b1;
                ctl.alu_op  = ALU_OR;
            end
            OPC_LOAD: begin
                ctl.reg_we      = 1'b1;
                ctl.opb_imm     = 1'b1;
                ctl.ext_signed  = 1'b1;
                ctl.wb_from_mem = 1'b1;
            end
            OPC_STOR: begin
                ctl.mem_we     = 1'b1;
                ctl.opb_imm    = 1'b1;
                ctl.ext_signed = 1'b1;
            end
            OPC_BEQ: begin
                ctl.is_branch  = 1'b1;
                ctl.ext_signed = 1'b1;
                ctl.alu_op     = ALU_SUB;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_core_pkg::*;
#(
    parameter int DEPTH = NREGS,
    parameter int WIDTH = XLEN,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr_a,
    input  logic [AW-1:0]    raddr_b,
    output logic [WIDTH-1:0] rdata_a,
    output logic [WIDTH-1:0] rdata_b
);

    logic [WIDTH-1:0] bank_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) bank_q[i] <= '0;
        end else if (we && waddr != '0) begin
            bank_q[waddr] <= wdata;
        end
    end

    assign rdata_a = (raddr_a == '0) ? '0 : bank_q[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : bank_q[raddr_b];

    // R8
    r0_port_a_chk: assert property (@(posedge clk) disable iff (rst)
        (raddr_a == '0) |-> (rdata_a == '0));
    // R8
    r0_port_b_chk: assert property (@(posedge clk) disable iff (rst)
        (raddr_b == '0) |-> (rdata_b == '0));
    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (we && waddr != '0) |=> (bank_q[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int WIDTH = XLEN
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  alu_op_e          op,
    output logic [WIDTH-1:0] res,
    output logic             is_zero
);

    always_comb begin
        unique case (op)
            ALU_SUB: res = opa - opb;
            ALU_OR:  res = opa | opb;
            default: res = opa + opb;
        endcase
    end

    assign is_zero = (res == '0);

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_rdata,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_wen,
    input  logic [31:0] dmem_rdata
);

    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0]      pc_q, pc_seq, pc_tgt, pc_nxt;
    insn_t                ins;
    ctrl_t                ctl;
    logic [XLEN-1:0]      rs_val, rt_val, ext_val, opb, alu_res, wb_val;
    logic [REG_IDX_W-1:0] wr_idx;
    logic                 alu_zero, rf_we;

    assign ins = insn_t'(imem_rdata);

    sc_decoder u_dec (
        .opc (ins.opc),
        .fn  (ins.fn),
        .ctl (ctl)
    );

    assign wr_idx = ctl.dst_from_rd ? ins.dst : ins.src_b;
    assign rf_we  = ctl.reg_we & ~rst;

    sc_regfile #(.DEPTH(NREGS), .WIDTH(XLEN)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we),
        .waddr   (wr_idx),
        .wdata   (wb_val),
        .raddr_a (ins.src_a),
        .raddr_b (ins.src_b),
        .rdata_a (rs_val),
        .rdata_b (rt_val)
    );

    assign ext_val = extend_imm(imem_rdata[IMM_W-1:0], ctl.ext_signed);
    assign opb     = ctl.opb_imm ? ext_val : rt_val;

    sc_alu #(.WIDTH(XLEN)) u_alu (
        .opa     (rs_val),
        .opb     (opb),
        .op      (ctl.alu_op),
        .res     (alu_res),
        .is_zero (alu_zero)
    );

    assign wb_val = ctl.wb_from_mem ? dmem_rdata : alu_res;

    assign pc_seq = pc_q + STEP;
    assign pc_tgt = pc_seq + {ext_val[XLEN-3:0], 2'b00};
    assign pc_nxt = (ctl.is_branch && alu_zero) ? pc_tgt : pc_seq;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_nxt;
    end

    assign imem_addr  = pc_q;
    assign dmem_addr  = alu_res;
    assign dmem_wdata = rt_val;
    assign dmem_wen   = ctl.mem_we & ~rst;

    // R1
    pc_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (imem_addr == '0));
    // R7
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (imem_rdata[31:26] != OPC_BEQ) |=> (imem_addr == $past(imem_addr) + STEP));
    // R6
    beq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (imem_rdata[31:26] == OPC_BEQ && rs_val != rt_val) |=> (imem_addr == $past(imem_addr) + STEP));
    // R5
    store_opc_chk: assert property (@(posedge clk) disable iff (rst)
        dmem_wen |-> (imem_rdata[31:26] == OPC_STOR));
    // R5
    store_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        dmem_wen |-> !rf_we);

endmodule

// File: tb/sim_sc_core.sv
module sim_sc_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_wen;

    logic [31:0] imem     [0:63];
    logic [31:0] dmem     [0:63];
    logic [31:0] ref_dmem [0:63];
    logic [31:0] ref_reg  [0:31];
    logic [31:0] ref_pc;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    sc_core u0 (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_wen   (dmem_wen),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) if (dmem_wen) dmem[dmem_addr[7:2]] <= dmem_wdata;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input int fn);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
    endfunction

    function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input int imm);
        return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    task automatic ref_write(input logic [4:0] idx, input logic [31:0] val);
        if (idx != 5'd0) ref_reg[idx] = val;
    endtask

    task automatic step_ref();
        logic [31:0] ins, a, b, sx, zx, ea, nxt;
        logic [5:0]  op, fn;
        logic [4:0]  rs, rt, rd;
        logic        exp_we;
        ins = imem[ref_pc[7:2]];
        op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11]; fn = ins[5:0];
        sx = {{16{ins[15]}}, ins[15:0]};
        zx = {16'h0000, ins[15:0]};
        a = ref_reg[rs]; b = ref_reg[rt];
        ea = a + sx;
        nxt = ref_pc + 32'd4;
        exp_we = 1'b0;
        check((op == 6'h04) ? "R6 fetch address" : "R7 fetch address", imem_addr, ref_pc);
        case (op)
            6'h00: begin
                if (fn == 6'h21) ref_write(rd, a + b);
                else if (fn == 6'h23) ref_write(rd, a - b);
            end
            6'h0D: ref_write(rt, a | zx);
            6'h23: ref_write(rt, ref_dmem[ea[7:2]]);
            6'h2B: begin
                exp_we = 1'b1;
                check("R5 store address", dmem_addr, ea);
                check("R5 store data", dmem_wdata, b);
                ref_dmem[ea[7:2]] = b;
            end
            6'h04: if (a == b) nxt = ref_pc + 32'd4 + (sx << 2);
            default: ;
        endcase
        check("R5 write enable", {31'd0, dmem_wen}, {31'd0, exp_we});
        ref_pc = nxt;
    endtask

    initial begin : watchdog
        #100000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 64; i++) begin
            imem[i] = 32'h0; dmem[i] = 32'h0; ref_dmem[i] = 32'h0;
        end
        for (int i = 0; i < 32; i++) ref_reg[i] = 32'h0;
        ref_pc = 32'h0;

        imem[0]  = enc_i(6'h2B, 0, 5, 0);          // store r5 (never written) -> R1
        imem[1]  = enc_i(6'h0D, 0, 1, 16'h8000);   // r1 = 0x8000, zero-extended R3
        imem[2]  = enc_i(6'h0D, 0, 2, 3);          // r2 = 3
        imem[3]  = enc_r(1, 2, 3, 6'h21);          // r3 = r1 + r2 R2
        imem[4]  = enc_r(2, 1, 4, 6'h23);          // r4 = r2 - r1 (wraps) R2
        imem[5]  = enc_i(6'h2B, 0, 3, 4);
        imem[6]  = enc_i(6'h2B, 0, 4, 8);
        imem[7]  = enc_i(6'h0D, 0, 0, 16'h0055);   // write to r0 discarded R8
        imem[8]  = enc_i(6'h2B, 0, 0, 12);
        imem[9]  = enc_i(6'h0D, 0, 6, 16'h0040);   // r6 = 64
        imem[10] = enc_i(6'h2B, 6, 3, -4);         // store at 60, negative offset
        imem[11] = enc_i(6'h23, 6, 7, -4);         // load from 60 R4
        imem[12] = enc_i(6'h2B, 0, 7, 16);
        imem[13] = 32'hFC42_1234;                  // unknown opcode R7
        imem[14] = enc_i(6'h04, 1, 2, 5);          // not taken R6
        imem[15] = enc_i(6'h04, 3, 7, 2);          // taken to 72 R6
        imem[16] = enc_i(6'h2B, 0, 1, 20);         // skipped
        imem[17] = enc_i(6'h2B, 0, 1, 24);         // skipped
        imem[18] = enc_i(6'h2B, 0, 4, 28);
        imem[19] = enc_i(6'h04, 0, 0, -1);         // loop in place

        repeat (3) @(negedge clk);
        check("R1 fetch address in reset", imem_addr, 32'h0);
        check("R5 write enable in reset", {31'd0, dmem_wen}, 32'd0);
        rst = 1'b0;
        #1;
        for (int c = 0; c < 40; c++) begin
            step_ref();
            @(negedge clk);
            #1;
        end

        check("R1 cleared register stored", dmem[0], 32'h0000_0000);
        check("R3 zero-extended sum", dmem[1], 32'h0000_8003);
        check("R2 wrapped difference", dmem[2], 32'hFFFF_8003);
        check("R8 register 0 after write", dmem[3], 32'h0000_0000);
        check("R5 negative-offset store", dmem[15], 32'h0000_8003);
        check("R4 loaded word", dmem[4], 32'h0000_8003);
        check("R6 skipped store a", dmem[5], 32'h0000_0000);
        check("R6 skipped store b", dmem[6], 32'h0000_0000);
        check("R6 branch target store", dmem[7], 32'hFFFF_8003);
        check("R6 self loop", imem_addr, 32'd76);
        for (int i = 0; i < 64; i++) check("R5 memory image", dmem[i], ref_dmem[i]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule